// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address by walking a two-level translation table in memory. A translation request comes in on a valid/ready handshake. The walker reads one word from the first-level table, which is located by a table base register. If that word points to a second-level table, the walker reads a second word from that table. It then returns either the translated physical address or a fault that carries the virtual address that failed, together with the table level at which the walk stopped.

Three mapping sizes are supported. A first-level entry can map a 1 MB section directly. A second-level entry can map a 64 KB large page or a 4 KB small page. A large page is stored as sixteen identical consecutive second-level entries, so any of the sixteen slots resolves to the same physical page. Only one walk is in progress at a time. The memory port is a plain read port: a one-cycle read strobe with a word address, answered some cycles later by a data-valid pulse.

Top module: `ptw_top`

## Requirements
- R1: After reset, `req_ready` is 1 and `res_valid`, `mem_rd` and `res_fault` are 0.
- R2: When a request is accepted, the walker pulses `mem_rd` for exactly one cycle. The read address is `{base[31:14], 14'b0} + va[31:20]*4`.
- R3: A first-level entry whose bits [1:0] are 00 or 11 ends the walk after one read. The result has `res_fault`=1, `res_fault_lvl`=0 and `res_addr` equal to the virtual address.
- R4: A first-level entry whose bits [1:0] are 10 is a section. The result has `res_fault`=0 and `res_addr` = {entry[31:20], va[19:0]}, after one read.
- R5: A first-level entry whose bits [1:0] are 01 causes a second read at `{entry[31:10], 10'b0} + va[19:12]*4`. Entry bits [9:2] are ignored.
- R6: A second-level entry whose bits [1:0] are 00 gives `res_fault`=1, `res_fault_lvl`=1 and `res_addr` equal to the virtual address.
- R7: A second-level entry whose bits [1:0] are 01 is a large page, and `res_addr` = {entry[31:16], va[15:0]}. Each of the sixteen replicated slots gives the same page.
- R8: A second-level entry with bit 1 set (bits [1:0] = 10 or 11) is a small page, and `res_addr` = {entry[31:12], va[11:0]}.
- R9: From the cycle after acceptance until the cycle after `res_valid`, `req_ready` is 0. `res_valid` is high for exactly one cycle, and `req_ready` returns to 1 the cycle after it.
- R10: A write on `base_we` stores `base_wdata[31:14]`, and bits [13:0] are ignored. Walks accepted afterwards use the new base.
- R11: A `mem_rvalid` pulse while no read is outstanding has no effect. No result appears, no read is issued, and the next walk returns the correct value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| base_we | input | 1 | Write strobe for the table base register |
| base_wdata | input | 32 | New table base; bits [13:0] are ignored |
| req_valid | input | 1 | Translation request valid |
| req_ready | output | 1 | Walker idle and able to accept a request |
| req_va | input | 32 | Virtual address to translate |
| mem_rd | output | 1 | One-cycle memory read strobe |
| mem_addr | output | 32 | Byte address of the table word being read |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Table word returned by memory |
| res_valid | output | 1 | Result valid for one cycle |
| res_addr | output | 32 | Physical address, or the virtual address on a fault |
| res_fault | output | 1 | Result is a translation fault |
| res_fault_lvl | output | 1 | Fault level: 0 = first level, 1 = second level |

## Verification
The bound checker watches the handshake rules on every cycle. It checks that `res_valid` lasts one cycle, is followed by `req_ready`, and never coincides with it. It also checks that each accepted request leads straight to a single, word-aligned read strobe, and that a successful result never carries a fault level. The bench scenarios cover what depends on table contents. These are the entry-type decoding for each level, the address concatenation for each page size, the second-level table address, and the ignored low base bits. The bench also shows that a stray data pulse while idle leaves no trace.

// File: rtl/ptw_pkg.sv
package ptw_pkg;

  typedef enum logic [1:0] {
    W_IDLE = 2'd0,
    W_LVL1 = 2'd1,
    W_LVL2 = 2'd2,
    W_RESP = 2'd3
  } walk_state_e;

  typedef enum logic [1:0] {
    K_FAULT = 2'd0,
    K_TABLE = 2'd1,
    K_SECT  = 2'd2
  } l1_kind_e;

endpackage

// File: rtl/ptw_base_reg.sv
module ptw_base_reg #(
  parameter int ADDR_W = 32,
  parameter int ALIGN  = 14
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [ADDR_W-1:0] wdata,
  output logic [ADDR_W-1:0] base
);
  localparam int HI_W = ADDR_W - ALIGN;

  logic [HI_W-1:0] hi_q;
  logic            unused_lo;

  assign unused_lo = ^wdata[ALIGN-1:0];

  always_ff @(posedge clk) begin
    if (rst) hi_q <= '0;
    else if (we) hi_q <= wdata[ADDR_W-1:ALIGN];
  end

  assign base = {hi_q, {ALIGN{1'b0}}};
endmodule

// File: rtl/ptw_l1_dec.sv
module ptw_l1_dec
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SECT_BITS   = 20,
  parameter int SMALL_BITS  = 12,
  parameter int L2TBL_ALIGN = 10
) (
  input  logic [ADDR_W-1:0]    entry,
  input  logic [SECT_BITS-1:0] va_lo,
  output l1_kind_e             kind,
  output logic [ADDR_W-1:0]    sect_pa,
  output logic [ADDR_W-1:0]    l2_addr
);
  localparam int L2_IDX_W = SECT_BITS - SMALL_BITS;
  localparam int PAD_W    = ADDR_W - L2_IDX_W - 2;

  logic unused_mid;
  assign unused_mid = ^entry[L2TBL_ALIGN-1:2];

  always_comb begin
    unique case (entry[1:0])
      2'b10:   kind = K_SECT;
      2'b01:   kind = K_TABLE;
      default: kind = K_FAULT;
    endcase
  end

  assign sect_pa = {entry[ADDR_W-1:SECT_BITS], va_lo};
  assign l2_addr = {entry[ADDR_W-1:L2TBL_ALIGN], {L2TBL_ALIGN{1'b0}}}
                 + {{PAD_W{1'b0}}, va_lo[SECT_BITS-1:SMALL_BITS], 2'b00};
endmodule

// File: rtl/ptw_l2_dec.sv
module ptw_l2_dec #(
  parameter int ADDR_W     = 32,
  parameter int LARGE_BITS = 16,
  parameter int SMALL_BITS = 12
) (
  input  logic [ADDR_W-1:0]     entry,
  input  logic [LARGE_BITS-1:0] va_lo,
  output logic                  fault,
  output logic [ADDR_W-1:0]     pa
);
  logic small_pg;
  logic unused_low;

  assign unused_low = ^entry[SMALL_BITS-1:2];
  assign small_pg   = entry[1];
  assign fault      = (entry[1:0] == 2'b00);

  always_comb begin
    if (small_pg) pa = {entry[ADDR_W-1:SMALL_BITS], va_lo[SMALL_BITS-1:0]};
    else          pa = {entry[ADDR_W-1:LARGE_BITS], va_lo};
  end
endmodule

// File: rtl/ptw_top.sv
module ptw_top
  import ptw_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SECT_BITS   = 20,
  parameter int LARGE_BITS  = 16,
  parameter int SMALL_BITS  = 12,
  parameter int L2TBL_ALIGN = 10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              base_we,
  input  logic [ADDR_W-1:0] base_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_va,
  output logic              mem_rd,
  output logic [ADDR_W-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [ADDR_W-1:0] mem_rdata,
  output logic              res_valid,
  output logic [ADDR_W-1:0] res_addr,
  output logic              res_fault,
  output logic              res_fault_lvl
);
  localparam int L1_IDX_W    = ADDR_W - SECT_BITS;
  localparam int L1TBL_ALIGN = L1_IDX_W + 2;
  localparam int L1_PAD_W    = ADDR_W - L1_IDX_W - 2;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] va_q;
  logic [ADDR_W-1:0] tbl_base;
  logic [ADDR_W-1:0] l1_addr;
  l1_kind_e          l1_kind;
  logic [ADDR_W-1:0] l1_sect_pa;
  logic [ADDR_W-1:0] l1_next;
  logic              l2_fault;
  logic [ADDR_W-1:0] l2_pa;

  ptw_base_reg #(.ADDR_W(ADDR_W), .ALIGN(L1TBL_ALIGN)) u_base (
    .clk(clk), .rst(rst), .we(base_we), .wdata(base_wdata), .base(tbl_base)
  );

  ptw_l1_dec #(
    .ADDR_W(ADDR_W), .SECT_BITS(SECT_BITS),
    .SMALL_BITS(SMALL_BITS), .L2TBL_ALIGN(L2TBL_ALIGN)
  ) u_l1 (
    .entry(mem_rdata), .va_lo(va_q[SECT_BITS-1:0]),
    .kind(l1_kind), .sect_pa(l1_sect_pa), .l2_addr(l1_next)
  );

  ptw_l2_dec #(
    .ADDR_W(ADDR_W), .LARGE_BITS(LARGE_BITS), .SMALL_BITS(SMALL_BITS)
  ) u_l2 (
    .entry(mem_rdata), .va_lo(va_q[LARGE_BITS-1:0]),
    .fault(l2_fault), .pa(l2_pa)
  );

  assign l1_addr   = tbl_base + {{L1_PAD_W{1'b0}}, req_va[ADDR_W-1:SECT_BITS], 2'b00};
  assign req_ready = (state_q == W_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q       <= W_IDLE;
      va_q          <= '0;
      mem_rd        <= 1'b0;
      mem_addr      <= '0;
      res_valid     <= 1'b0;
      res_addr      <= '0;
      res_fault     <= 1'b0;
      res_fault_lvl <= 1'b0;
    end else begin
      mem_rd    <= 1'b0;
      res_valid <= 1'b0;
      unique case (state_q)
        W_IDLE: begin
          if (req_valid) begin
            va_q     <= req_va;
            mem_rd   <= 1'b1;
            mem_addr <= l1_addr;
            state_q  <= W_LVL1;
          end
        end
        W_LVL1: begin
          if (mem_rvalid) begin
            unique case (l1_kind)
              K_TABLE: begin
                mem_rd   <= 1'b1;
                mem_addr <= l1_next;
                state_q  <= W_LVL2;
              end
              K_SECT: begin
                res_valid     <= 1'b1;
                res_addr      <= l1_sect_pa;
                res_fault     <= 1'b0;
                res_fault_lvl <= 1'b0;
                state_q       <= W_RESP;
              end
              default: begin
                res_valid     <= 1'b1;
                res_addr      <= va_q;
                res_fault     <= 1'b1;
                res_fault_lvl <= 1'b0;
                state_q       <= W_RESP;
              end
            endcase
          end
        end
        W_LVL2: begin
          if (mem_rvalid) begin
            res_valid     <= 1'b1;
            res_addr      <= l2_fault ? va_q : l2_pa;
            res_fault     <= l2_fault;
            res_fault_lvl <= l2_fault;
            state_q       <= W_RESP;
          end
        end
        default: state_q <= W_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/ptw_chk.sv
module ptw_chk #(
  parameter int ADDR_W = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic              mem_rd,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              res_valid,
  input logic              res_fault,
  input logic              res_fault_lvl
);
  // R9: a result is one cycle long
  a_r9_res_pulse: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> !res_valid);

  // R9: walker is idle again right after a result
  a_r9_ready_after_res: assert property (@(posedge clk) disable iff (rst)
    res_valid |=> req_ready);

  // R9: no new request accepted while a result is presented
  a_r9_busy_on_res: assert property (@(posedge clk) disable iff (rst)
    res_valid |-> !req_ready);

  // R2: acceptance starts the first-level read at once
  a_r2_accept_reads: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready) |=> (mem_rd && !req_ready));

  // R2: read strobe is a single cycle
  a_r2_rd_pulse: assert property (@(posedge clk) disable iff (rst)
    mem_rd |=> !mem_rd);

  // R5: table reads are word aligned
  a_r5_word_aligned: assert property (@(posedge clk) disable iff (rst)
    mem_rd |-> (mem_addr[1:0] == 2'b00));

  // R4: a good translation carries no fault level
  a_r4_ok_no_lvl: assert property (@(posedge clk) disable iff (rst)
    (res_valid && !res_fault) |-> !res_fault_lvl);

  // R1: no read while idle
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> !mem_rd);
endmodule

bind ptw_top ptw_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst(rst), .req_valid(req_valid), .req_ready(req_ready),
  .mem_rd(mem_rd), .mem_addr(mem_addr), .res_valid(res_valid),
  .res_fault(res_fault), .res_fault_lvl(res_fault_lvl)
);

// File: tb/tb_ptw_top.sv
`timescale 1ns/1ps
module tb_ptw_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        base_we = 1'b0;
  logic [31:0] base_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_va = '0;
  logic        mem_rd;
  logic [31:0] mem_addr;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;
  logic        res_valid;
  logic [31:0] res_addr;
  logic        res_fault;
  logic        res_fault_lvl;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  ptw_top dut (
    .clk(clk), .rst(rst), .base_we(base_we), .base_wdata(base_wdata),
    .req_valid(req_valid), .req_ready(req_ready), .req_va(req_va),
    .mem_rd(mem_rd), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata), .res_valid(res_valid), .res_addr(res_addr),
    .res_fault(res_fault), .res_fault_lvl(res_fault_lvl)
  );

  // sparse table memory with a configurable latency
  logic [31:0] pmem [logic [31:0]];
  int          mem_lat = 1;
  int          lat_cnt = 0;
  bit          pend = 0;
  logic [31:0] pend_a = '0;
  int          rd_cnt = 0;
  logic [31:0] rd_a0 = '0, rd_a1 = '0;
  bit          stray = 0;

  function automatic logic [31:0] rd_word(input logic [31:0] a);
    if (pmem.exists(a)) return pmem[a];
    return 32'h0;
  endfunction

  always @(posedge clk) begin
    mem_rvalid <= 1'b0;
    if (stray) begin
      mem_rvalid <= 1'b1;
      mem_rdata  <= 32'h8760_000E;
    end else if (mem_rd) begin
      pend    <= 1;
      lat_cnt <= mem_lat;
      pend_a  <= mem_addr;
      if (rd_cnt == 0) rd_a0 <= mem_addr;
      else             rd_a1 <= mem_addr;
      rd_cnt  <= rd_cnt + 1;
    end else if (pend) begin
      if (lat_cnt <= 1) begin
        mem_rvalid <= 1'b1;
        mem_rdata  <= rd_word(pend_a);
        pend       <= 0;
      end else lat_cnt <= lat_cnt - 1;
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input int lat,
                      output logic [31:0] addr, output logic flt, output logic lvl,
                      output int nrd, output bit hs_ok);
    int waits;
    @(negedge clk);
    mem_lat = lat; rd_cnt = 0; req_va = va; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0; hs_ok = 1; waits = 0;
    while (!res_valid && waits < 200) begin
      if (req_ready) hs_ok = 0;
      @(negedge clk);
      waits++;
    end
    if (waits >= 200) hs_ok = 0;
    addr = res_addr; flt = res_fault; lvl = res_fault_lvl;
    if (req_ready) hs_ok = 0;
    @(negedge clk);
    if (res_valid || !req_ready) hs_ok = 0;
    nrd = rd_cnt;
  endtask

  localparam logic [31:0] BASE = 32'h0010_0000;
  localparam logic [31:0] L2B  = 32'h0020_0400;
  localparam int NV = 9;
  localparam logic [31:0] V_VA  [NV] = '{32'h0001_2345, 32'h0034_5678, 32'h1234_5678,
    32'h4000_5ABC, 32'h4000_6DEF, 32'h4001_2345, 32'h4001_F00C, 32'h4002_0000, 32'h123F_FFFF};
  localparam logic [31:0] V_EXP [NV] = '{32'h0001_2345, 32'h0034_5678, 32'h8764_5678,
    32'h1357_9ABC, 32'h2468_ADEF, 32'h5555_2345, 32'h5555_F00C, 32'h4002_0000, 32'h876F_FFFF};
  localparam logic V_FLT [NV] = '{1'b1, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam logic V_LVL [NV] = '{1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 1'b0};
  localparam int   V_NRD [NV] = '{1, 1, 1, 2, 2, 2, 2, 2, 1};

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual running expected done");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin : main
    string tags [NV];
    logic [31:0] a;
    logic f, l;
    int nr;
    bit hs;
    tags = '{"R3", "R3", "R4", "R8", "R8", "R7", "R7", "R6", "R4"};

    // table contents
    pmem[BASE + 32'h003*4] = 32'hABC0_0003;   // type 11 fault
    pmem[BASE + 32'h123*4] = 32'h876A_BC0E;   // section
    pmem[BASE + 32'h400*4] = 32'h0020_07FD;   // second-level pointer, junk in [9:2]
    pmem[L2B + 32'h05*4]   = 32'h1357_9002;   // small, type 10
    pmem[L2B + 32'h06*4]   = 32'h2468_A003;   // small, type 11
    for (int i = 16; i < 32; i++) pmem[L2B + i*4] = 32'h5555_0001; // large x16

    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 ready", {31'b0, req_ready}, 32'd1);
    chk("R1 res_valid", {31'b0, res_valid}, 32'd0);
    chk("R1 mem_rd", {31'b0, mem_rd}, 32'd0);
    chk("R1 res_fault", {31'b0, res_fault}, 32'd0);
    rst = 1'b0;
    @(negedge clk);
    base_we = 1'b1; base_wdata = BASE;
    @(negedge clk);
    base_we = 1'b0;

    for (int v = 0; v < NV; v++) begin
      walk(V_VA[v], 1 + (v % 3), a, f, l, nr, hs);
      chk({tags[v], " addr"}, a, V_EXP[v]);
      chk({tags[v], " fault"}, {31'b0, f}, {31'b0, V_FLT[v]});
      chk({tags[v], " level"}, {31'b0, l}, {31'b0, V_LVL[v]});
      chk("R9 handshake", {31'b0, hs}, 32'd1);
      chk("R2 read count", nr, V_NRD[v]);
      chk("R2 level-1 address", rd_a0, BASE + {18'b0, V_VA[v][31:20], 2'b00});
      if (V_NRD[v] == 2)
        chk("R5 level-2 address", rd_a1, L2B + {22'b0, V_VA[v][19:12], 2'b00});
    end

    // R10: low base bits ignored
    @(negedge clk); base_we = 1'b1; base_wdata = BASE | 32'h0000_3FFF;
    @(negedge clk); base_we = 1'b0;
    walk(32'h1234_5678, 2, a, f, l, nr, hs);
    chk("R10 low bits ignored addr", rd_a0, 32'h0010_048C);
    chk("R10 low bits ignored result", a, 32'h8764_5678);

    // R10: new base takes effect
    @(negedge clk); base_we = 1'b1; base_wdata = 32'h0050_0000;
    @(negedge clk); base_we = 1'b0;
    walk(32'h1234_5678, 1, a, f, l, nr, hs);
    chk("R10 new base addr", rd_a0, 32'h0050_048C);
    chk("R10 new base fault", {31'b0, f}, 32'd1);

    @(negedge clk); base_we = 1'b1; base_wdata = BASE;
    @(negedge clk); base_we = 1'b0;

    // R11: stray data pulse while idle
    stray = 1;
    @(negedge clk); stray = 0;
    for (int k = 0; k < 4; k++) begin
      @(negedge clk);
      chk("R11 no result", {31'b0, res_valid}, 32'd0);
      chk("R11 still ready", {31'b0, req_ready}, 32'd1);
      chk("R11 no read", {31'b0, mem_rd}, 32'd0);
    end
    walk(32'h4000_5ABC, 3, a, f, l, nr, hs);
    chk("R11 next walk", a, 32'h1357_9ABC);
    chk("R9 handshake after stray", {31'b0, hs}, 32'd1);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule